// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a byte-addressed bank of shared counters that many requesters update without locks. Each request names a byte address, an operand size of 8, 16, 32 or 64 bits, and one of two kinds of access. A load carries a small signed increment inside the request word. It returns the value the counter held before the update and writes back the sum, so one read does both the fetch and the add. A store carries a data word. It either adds that word to the counter or replaces the counter with it.

A load may also ask to wait for an external "tag switch done" event before it updates. While it waits, the block stalls its request port. If the event never arrives within a parameterised number of cycles, the load gives up. It then returns a result word whose top operand bit is set as an error flag, and it leaves the counter as it was. Every request passes through one read-modify-write path, one at a time, so back-to-back requests to the same counter never lose an update.

Top module: `atomic_counter_bank`

## Requirements
- R1: The request word `reqCmd` holds the byte address in bits 10:0, the operand size in bits 12:11 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit), a flag in bit 13 and the increment in bits 35:14. Bytes are little-endian: byte address a is byte lane a mod 8 of 64-bit word a/8. The operand is formed from the bytes starting at a, and load results are returned zero-extended in `rspData`.
- R2: A load without the wait flag takes the 22-bit increment from bits 35:14 and sign-extends it. It adds the increment to the counter modulo 2^width and returns the old value.
- R3: A store with bit 13 = 0 adds the low operand-width bits of `reqData` to the counter, wrapping modulo 2^width. A store with bit 13 = 1 overwrites the counter with those bits. A store's response has `rspData` = 0 and `rspError` = 0.
- R4: An update changes only the bytes of the addressed operand. All other bytes of the bank keep their values.
- R5: A request whose address is not a multiple of the operand size in bytes gets `rspError` = 1 and `rspData` = 0, and the bank is left unchanged. Such a request never waits, even when it is a load with the wait flag set.
- R6: A request that does not wait is accepted on any edge where `reqValid` and `reqReady` are both high. Its response appears on the very next cycle. Requests may follow each other every cycle, and each one sees the result of the one before.
- R7: A load with bit 13 set and a correctly aligned address holds `reqReady` low until `tagDone` is high. The update is done on that edge, and the response follows one cycle later. Its bit width-1 is 0 and its lower bits hold the old value.
- R8: If `tagDone` stays low through TIMEOUT waiting cycles, the load responds with only bit width-1 of `rspData` set and `rspError` = 0. The counter is left unchanged.
- R9: After reset every counter reads zero, `rspValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqIsStore | input | 1 | 1 = store request, 0 = load request |
| reqCmd | input | 36 | Request word: increment, flag, size, byte address |
| reqData | input | 64 | Store data (ignored on loads) |
| tagDone | input | 1 | Pending tag switch has completed |
| reqReady | output | 1 | Block can accept a request |
| rspValid | output | 1 | Response present this cycle |
| rspError | output | 1 | Misaligned request rejected |
| rspData | output | 64 | Old value, flagged result, or zero |

## Verification
A request that does not wait must produce its response one cycle after it is accepted. A waiting load answers one cycle after the edge on which `tagDone` is seen high. A load that times out answers TIMEOUT+1 cycles after it is accepted. The bench drives inputs on falling edges and counts falling edges from acceptance until `rspValid` appears. It checks that count against the latency expected for the request, and it samples data and error only on that falling edge. A byte-wise model of the bank computes every expected result. A final sweep reads back whole words to show that no byte outside an operand, and no byte touched by a rejected or timed-out request, has changed.

// File: rtl/atomic_bank_pkg.sv
package atomic_bank_pkg;
  localparam int CMD_W    = 36;
  localparam int DATA_W   = 64;
  localparam int SIZE_LSB = 11;
  localparam int FLAG_BIT = 13;
  localparam int INC_LSB  = 14;
  localparam int INC_W    = 22;

  typedef struct packed {
    logic              isStore;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } reqT;

  // control -> datapath strobes
  typedef struct packed {
    logic exec;      // perform the read-modify-write now
    logic timedOut;  // give up on a waiting load
    reqT  req;
  } strobeT;

  function automatic logic isAligned(input logic [1:0] size, input logic [2:0] low);
    case (size)
      2'd0:    return 1'b1;
      2'd1:    return low[0] == 1'b0;
      2'd2:    return low[1:0] == 2'b00;
      default: return low == 3'b000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sizeMask(input logic [1:0] size);
    case (size)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/atomic_bank_ctrl.sv
module atomic_bank_ctrl
  import atomic_bank_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqData,
  input  logic              tagDone,
  output logic              reqReady,
  output strobeT            strobe
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);

  typedef enum logic {ST_IDLE, ST_WAIT} stateT;

  stateT            state;
  logic [CNT_W-1:0] waitCnt;
  reqT              held;
  reqT              incoming;
  logic             mustWait;

  always_comb begin
    incoming.isStore = reqIsStore;
    incoming.cmd     = reqCmd;
    incoming.data    = reqData;
    mustWait = !reqIsStore && reqCmd[FLAG_BIT] &&
               isAligned(reqCmd[SIZE_LSB +: 2], reqCmd[2:0]);
    reqReady = (state == ST_IDLE);
    strobe   = '0;
    if (state == ST_IDLE) begin
      strobe.req  = incoming;
      strobe.exec = reqValid && !mustWait;
    end else begin
      strobe.req      = held;
      strobe.exec     = tagDone;
      strobe.timedOut = !tagDone && (waitCnt == LAST_CNT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      held    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid && mustWait) begin
            held    <= incoming;
            waitCnt <= '0;
            state   <= ST_WAIT;
          end
        end
        default: begin
          if (strobe.exec || strobe.timedOut) state <= ST_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/atomic_bank_dp.sv
module atomic_bank_dp
  import atomic_bank_pkg::*;
#(
  parameter int NUM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);
  localparam int ADDR_W = $clog2(NUM_BYTES);
  localparam int WORDS  = NUM_BYTES / 8;
  localparam int IDX_W  = ADDR_W - 3;

  logic [DATA_W-1:0] bank [WORDS];

  logic [1:0]        size;
  logic [2:0]        lane;
  logic [IDX_W-1:0]  idx;
  logic [5:0]        shiftAmt;
  logic              aligned;
  logic              overwrite;
  logic              tagLoad;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] topBit;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] newVal;
  logic [DATA_W-1:0] newWord;

  always_comb begin
    size      = strobe.req.cmd[SIZE_LSB +: 2];
    lane      = strobe.req.cmd[2:0];
    idx       = strobe.req.cmd[3 +: IDX_W];
    shiftAmt  = {lane, 3'b000};
    aligned   = isAligned(size, lane);
    mask      = sizeMask(size);
    topBit    = mask ^ (mask >> 1);
    overwrite = strobe.req.isStore && strobe.req.cmd[FLAG_BIT];
    tagLoad   = !strobe.req.isStore && strobe.req.cmd[FLAG_BIT];
    curWord   = bank[idx];
    oldVal    = (curWord >> shiftAmt) & mask;
    if (strobe.req.isStore)
      operand = strobe.req.data;
    else
      operand = {{(DATA_W-INC_W){strobe.req.cmd[INC_LSB+INC_W-1]}},
                 strobe.req.cmd[INC_LSB +: INC_W]};
    newVal  = (overwrite ? operand : (oldVal + operand)) & mask;
    newWord = (curWord & ~(mask << shiftAmt)) | (newVal << shiftAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) bank[w] <= '0;
    end else if (strobe.exec && aligned) begin
      bank[idx] <= newWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.exec || strobe.timedOut;
      rspError <= 1'b0;
      rspData  <= '0;
      if (strobe.timedOut) begin
        rspData <= topBit;
      end else if (strobe.exec) begin
        if (!aligned)                rspError <= 1'b1;
        else if (strobe.req.isStore) rspData  <= '0;
        else if (tagLoad)            rspData  <= oldVal & ~topBit;
        else                         rspData  <= oldVal;
      end
    end
  end
endmodule

// File: rtl/atomic_counter_bank.sv
module atomic_counter_bank
  import atomic_bank_pkg::*;
#(
  parameter int NUM_BYTES = 2048,
  parameter int TIMEOUT   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqData,
  input  logic              tagDone,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);
  strobeT strobe;

  atomic_bank_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqCmd(reqCmd), .reqData(reqData), .tagDone(tagDone),
    .reqReady(reqReady), .strobe(strobe)
  );

  atomic_bank_dp #(.NUM_BYTES(NUM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
  );
endmodule

// File: rtl/atomic_counter_bank_chk.sv
module atomic_counter_bank_chk
  import atomic_bank_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqIsStore,
  input logic [CMD_W-1:0]  reqCmd,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspError,
  input logic [DATA_W-1:0] rspData
);
  logic accepted;
  logic waits;
  assign accepted = reqValid && reqReady;
  assign waits = !reqIsStore && reqCmd[FLAG_BIT] &&
                 isAligned(reqCmd[SIZE_LSB +: 2], reqCmd[2:0]);

  p_rsp_next_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !waits |=> rspValid);

  p_stall_on_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    accepted && waits |=> !reqReady && !rspValid);

  p_ready_with_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  p_reject_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspError |-> rspData == '0);

  p_store_rsp_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    accepted && reqIsStore |=> rspData == '0);
endmodule

bind atomic_counter_bank atomic_counter_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
  .reqCmd(reqCmd), .reqReady(reqReady), .rspValid(rspValid),
  .rspError(rspError), .rspData(rspData)
);

// File: tb/atomic_counter_bank_tb.sv
module atomic_counter_bank_tb;
  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsStore = 1'b0;
  logic [35:0] reqCmd = '0;
  logic [63:0] reqData = '0;
  logic        tagDone = 1'b0;
  logic        reqReady, rspValid, rspError;
  logic [63:0] rspData;

  int checks = 0;
  int errors = 0;
  logic [7:0] refMem [2048];

  always #5 clk = ~clk;

  atomic_counter_bank #(.NUM_BYTES(2048), .TIMEOUT(T)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqCmd(reqCmd), .reqData(reqData), .tagDone(tagDone),
    .reqReady(reqReady), .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] maskOf(input int nb);
    return (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
  endfunction

  // One request; tagDelay = falling edge (after acceptance) on which tagDone is raised, 0 = never
  task automatic runOp(input string req, input bit isStore, input int size, input int addr,
                       input bit flag, input logic [21:0] inc, input logic [63:0] data,
                       input int tagDelay);
    int nb = 1 << size;
    logic [63:0] mask = maskOf(nb);
    logic [63:0] top = mask ^ (mask >> 1);
    bit aligned = (addr % nb) == 0;
    logic [63:0] old = '0;
    logic [63:0] op, nv, expData;
    int expLat, lat;
    bit doUpdate, waitOp, gotRsp;
    if (aligned) for (int i = 0; i < nb; i++) old |= 64'(refMem[addr+i]) << (8 * i);
    waitOp = aligned && !isStore && flag;
    doUpdate = aligned;
    expLat = 1;
    if (!aligned) expData = '0;
    else if (isStore) expData = '0;
    else if (!flag) expData = old;
    else if (tagDelay >= 1 && tagDelay <= T) begin
      expData = old & ~top; expLat = tagDelay + 1;
    end else begin
      expData = top; expLat = T + 1; doUpdate = 0;
    end
    op = isStore ? data : {{42{inc[21]}}, inc};
    nv = (isStore && flag) ? (op & mask) : ((old + op) & mask);

    check(req, "ready before request", {63'd0, reqReady}, 64'd1);
    reqValid = 1'b1; reqIsStore = isStore; reqData = data;
    reqCmd = {inc, flag, 2'(size), 11'(addr)};
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; gotRsp = 0;
    while (lat <= T + 3) begin
      if (rspValid) begin gotRsp = 1; break; end
      if (lat == 1 && waitOp) check("R7", "ready while waiting", {63'd0, reqReady}, 64'd0);
      tagDone = (lat == tagDelay);
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    tagDone = 1'b0;
    check(req, "latency", 64'(gotRsp ? lat : -1), 64'(expLat));
    check(req, "rspError", {63'd0, rspError}, {63'd0, !aligned});
    check(req, "rspData", rspData, expData);
    if (doUpdate) for (int i = 0; i < nb; i++) refMem[addr+i] = nv[8*i +: 8];
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    for (int i = 0; i < 2048; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R9", "rspValid in reset", {63'd0, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "ready after reset", {63'd0, reqReady}, 64'd1);
    check("R9", "rspValid after reset", {63'd0, rspValid}, 64'd0);
    runOp("R9", 0, 3, 8, 0, 22'd0, 0, 0);                // counter reads zero
    // R2 wrap and sign extension
    runOp("R2", 0, 0, 5, 0, 22'h3FFFFF, 0, 0);           // -1 on 8-bit
    runOp("R2", 0, 0, 5, 0, 22'd0, 0, 0);                 // now 0xFF
    runOp("R2", 0, 2, 16, 0, 22'h1FFFFF, 0, 0);          // max positive
    runOp("R2", 0, 2, 16, 0, 22'h200000, 0, 0);          // most negative
    runOp("R2", 0, 2, 16, 0, 22'd0, 0, 0);
    // R3 store overwrite / add
    runOp("R3", 1, 1, 32, 1, 0, 64'hABCD_1234, 0);
    runOp("R3", 1, 1, 32, 0, 0, 64'h0001_0001, 0);
    runOp("R3", 0, 1, 32, 0, 22'd0, 0, 0);                // expect 0x1235
    runOp("R3", 1, 3, 40, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    runOp("R3", 1, 3, 40, 0, 0, 64'd2, 0);                // wraps to 1
    // R1 byte lanes: 64-bit read of word at 32..39
    runOp("R1", 0, 3, 32, 0, 22'd0, 0, 0);
    // R6 back-to-back on one counter
    for (int k = 0; k < 4; k++) runOp("R6", 0, 1, 50, 0, 22'd3, 0, 0);
    // R5 misaligned, including a waiting load
    runOp("R5", 0, 2, 18, 0, 22'd7, 0, 0);
    runOp("R5", 1, 3, 44, 1, 0, 64'h55, 0);
    runOp("R5", 0, 1, 51, 1, 22'd1, 0, 0);
    // R7 tag-wait success, incl. the last cycle
    runOp("R7", 0, 1, 50, 1, 22'd1, 0, 3);
    runOp("R7", 0, 0, 5, 1, 22'd1, 0, T);
    runOp("R7", 0, 3, 40, 1, 22'd0, 0, 1);
    // R8 timeout
    runOp("R8", 0, 2, 16, 1, 22'd9, 0, 0);
    runOp("R8", 0, 1, 50, 1, 22'd9, 0, T + 1);
    // random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int sz = $urandom % 4;
      int nb = 1 << sz;
      int ad = $urandom % 64;
      bit st = $urandom % 2;
      bit fl = ($urandom % 3) == 0;
      logic [21:0] inc = ($urandom % 2) ? 22'($urandom) : 22'($urandom % 8);
      logic [63:0] dt = {$urandom, $urandom};
      int dl = $urandom % (T + 3);
      if ($urandom % 8 != 0) ad = ad & ~(nb - 1);
      if (ad % nb != 0) tag = "R5";
      else if (st) tag = "R3";
      else if (!fl) tag = "R2";
      else if (dl >= 1 && dl <= T) tag = "R7";
      else tag = "R8";
      runOp(tag, st, sz, ad, fl, inc, dt, dl);
    end
    // R4 sweep: whole words must match the byte model
    for (int w = 0; w < 9; w++) runOp("R4", 0, 3, 8 * w, 0, 22'd0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule